// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block controls eight general-purpose I/O pins behind a 32-bit word register interface. For each pin, software picks one of four drive modes: input, push-pull output, open-drain output or open-source output. Software also sets an output data bit and an active-low pull-up control bit. The block turns these settings into per-pin pad controls: output value, output enable and pull-up enable. Every pad input can be read back at any time, whatever the pin's mode.

Each pin has its own edge detector. It is armed for either the rising or the falling edge, never both. A matching edge sets a sticky event bit, which software clears by writing 1 to it. A force register lets a test set event bits without any pad activity. The enabled event bits are ORed together into one registered port interrupt.

The pad inputs pass through a two-flop synchronizer before they reach the edge detector or the read path. The register file uses a 6-bit byte address and a combinational read path. A write is committed on the clock edge at which `wr_en` is high.

Top module: `gedge_port`

## Requirements
- R1: After reset every register reads 0, every `pad_oe` bit is 0, every `pad_pu_en` bit is 1 and `irq` is 0.
- R2: Each writable register reads back bits [7:0] as written. These are output data at 0x08, pull-up disable at 0x10, interrupt enable at 0x18, force at 0x1C and edge select at 0x20. The pin-mode register at 0x0C reads back bits [15:0]. Unused upper bits read 0, and any unmapped offset reads 0.
- R3: Offset 0x04 returns the pad inputs, delayed by the two-flop synchronizer, in every drive mode. A write to 0x04 has no effect.
- R4: The pin-mode field of pin n is bits [2n+1:2n] of 0x0C, encoded as follows.
  - 00 (input): `pad_oe` is 0 and `pad_out` is 0.
  - 01 (push-pull): `pad_oe` is 1 and `pad_out` equals the data bit.
  - 10 (open-drain): `pad_oe` is the inverse of the data bit and `pad_out` is 0.
  - 11 (open-source): `pad_oe` is the data bit and `pad_out` is 1.
- R5: `pad_pu_en[n]` is the inverse of bit n of 0x10. A 1 in that bit disables the pull-up.
- R6: The output data bit keeps its value while the pin is in input mode, and it is driven as soon as an output mode is selected.
- R7: Bit n of 0x20 selects the edge that sets event bit n. A value of 1 selects the rising edge and 0 selects the falling edge. The opposite edge leaves the event bit at 0.
- R8: Event bits at 0x14 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: When a set and a write-1 clear of the same event bit fall in one cycle, the bit stays set.
- R10: While force bit n at 0x1C is 1, event bit n is set every cycle. After 0 is written to the force bit, a clear of the event bit holds.
- R11: `irq` is a register that holds the OR over all pins of event AND enable. It stays 0 when no set event bit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, committed at the clock edge |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu_en | output | 8 | Pad pull-up enable |
| irq | output | 1 | Registered combined port interrupt |

## Verification
The event bits can be set by hardware and cleared by software in the same cycle. The bench provokes this by holding a force bit at 1, which sets the event bit on every clock edge, and then writing 1 to that event bit at offset 0x14. The bit must still read 1 afterwards. Once the force bit is dropped, the same write-1 clear must take effect. This shows the clear path works and that the priority between set and clear is what keeps the bit set.

// File: rtl/gep_pkg.sv
package gep_pkg;

    localparam int PORT_PINS = 8;
    localparam int BUS_W     = 32;
    localparam int OFS_W     = 6;

    localparam logic [OFS_W-1:0] OFS_DIN  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_DOUT = 6'h08;
    localparam logic [OFS_W-1:0] OFS_MODE = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_PUD  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_EVT  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_IEN  = 6'h18;
    localparam logic [OFS_W-1:0] OFS_FRC  = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_EDGE = 6'h20;

    typedef enum logic [1:0] {
        MODE_IN = 2'b00,
        MODE_PP = 2'b01,
        MODE_OD = 2'b10,
        MODE_OS = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drv_t;

    function automatic pad_drv_t drive_for(input pin_mode_e m, input logic d);
        pad_drv_t r;
        unique case (m)
            MODE_PP: begin r.oe = 1'b1; r.val = d;    end
            MODE_OD: begin r.oe = ~d;   r.val = 1'b0; end
            MODE_OS: begin r.oe = d;    r.val = 1'b1; end
            default: begin r.oe = 1'b0; r.val = 1'b0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gep_sync.sv
module gep_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] now_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end
endmodule

// File: rtl/gep_edge_evt.sv
module gep_edge_evt #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] lvl_now,
    input  logic [NPIN-1:0] lvl_prev,
    input  logic [NPIN-1:0] rise_sel,
    input  logic [NPIN-1:0] force_on,
    input  logic [NPIN-1:0] ien,
    input  logic            clr_we,
    input  logic [NPIN-1:0] clr_mask,
    output logic [NPIN-1:0] evt_q,
    output logic            irq_q
);
    logic [NPIN-1:0] hit;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic rose_i, fell_i;
        assign rose_i = lvl_now[i] & ~lvl_prev[i];
        assign fell_i = ~lvl_now[i] & lvl_prev[i];
        assign hit[i] = (rise_sel[i] ? rose_i : fell_i) | force_on[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            evt_q <= (evt_q & ~(clr_we ? clr_mask : '0)) | hit;
            irq_q <= |(evt_q & ien);
        end
    end
endmodule

// File: rtl/gep_pad_drive.sv
module gep_pad_drive
    import gep_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic [2*NPIN-1:0] mode_bits,
    input  logic [NPIN-1:0]   dout,
    input  logic [NPIN-1:0]   pud,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_pu_en
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pad_drv_t d;
        assign d            = drive_for(pin_mode_e'(mode_bits[2*i +: 2]), dout[i]);
        assign pad_out[i]   = d.val;
        assign pad_oe[i]    = d.oe;
        assign pad_pu_en[i] = ~pud[i];
    end
endmodule

// File: rtl/gedge_port.sv
module gedge_port
    import gep_pkg::*;
#(
    parameter int NPIN   = PORT_PINS,
    parameter int DATA_W = BUS_W,
    parameter int ADDR_W = OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_pu_en,
    output logic              irq
);
    localparam int MODE_W = 2 * NPIN;

    logic [NPIN-1:0]   dout_q, pud_q, ien_q, frc_q, rise_q;
    logic [MODE_W-1:0] mode_q;
    logic [NPIN-1:0]   lvl_now, lvl_prev, evt_q;
    logic              evt_clr_we;

    gep_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst(rst), .raw(pad_in),
        .now_q(lvl_now), .prev_q(lvl_prev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            mode_q <= '0;
            pud_q  <= '0;
            ien_q  <= '0;
            frc_q  <= '0;
            rise_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_DOUT: dout_q <= wdata[NPIN-1:0];
                OFS_MODE: mode_q <= wdata[MODE_W-1:0];
                OFS_PUD:  pud_q  <= wdata[NPIN-1:0];
                OFS_IEN:  ien_q  <= wdata[NPIN-1:0];
                OFS_FRC:  frc_q  <= wdata[NPIN-1:0];
                OFS_EDGE: rise_q <= wdata[NPIN-1:0];
                default: ;
            endcase
        end
    end

    assign evt_clr_we = wr_en && (addr == OFS_EVT);

    gep_edge_evt #(.NPIN(NPIN)) u_evt (
        .clk(clk), .rst(rst),
        .lvl_now(lvl_now), .lvl_prev(lvl_prev),
        .rise_sel(rise_q), .force_on(frc_q), .ien(ien_q),
        .clr_we(evt_clr_we), .clr_mask(wdata[NPIN-1:0]),
        .evt_q(evt_q), .irq_q(irq)
    );

    gep_pad_drive #(.NPIN(NPIN)) u_pad (
        .mode_bits(mode_q), .dout(dout_q), .pud(pud_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_DIN:  rdata[NPIN-1:0]   = lvl_now;
            OFS_DOUT: rdata[NPIN-1:0]   = dout_q;
            OFS_MODE: rdata[MODE_W-1:0] = mode_q;
            OFS_PUD:  rdata[NPIN-1:0]   = pud_q;
            OFS_EVT:  rdata[NPIN-1:0]   = evt_q;
            OFS_IEN:  rdata[NPIN-1:0]   = ien_q;
            OFS_FRC:  rdata[NPIN-1:0]   = frc_q;
            OFS_EDGE: rdata[NPIN-1:0]   = rise_q;
            default:  rdata             = '0;
        endcase
    end
endmodule

// File: rtl/gep_port_chk.sv
module gep_port_chk
    import gep_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic              irq,
    input logic [2*NPIN-1:0] mode_q,
    input logic [NPIN-1:0]   evt_q,
    input logic [NPIN-1:0]   ien_q,
    input logic [NPIN-1:0]   frc_q
);
    a_r11_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(evt_q & ien_q)));

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        a_r4_input_no_drive: assert property (@(posedge clk) disable iff (rst)
            (mode_q[2*i +: 2] == 2'b00) |-> !pad_oe[i]);

        a_r4_open_drain_low: assert property (@(posedge clk) disable iff (rst)
            (mode_q[2*i +: 2] == 2'b10 && pad_oe[i]) |-> !pad_out[i]);

        a_r8_event_sticky: assert property (@(posedge clk) disable iff (rst)
            (evt_q[i] && !(wr_en && addr == OFS_EVT && wdata[i])) |=> evt_q[i]);

        a_r10_force_sets: assert property (@(posedge clk) disable iff (rst)
            frc_q[i] |=> evt_q[i]);
    end
endmodule

bind gedge_port gep_port_chk #(.NPIN(NPIN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
    .mode_q(mode_q), .evt_q(evt_q), .ien_q(ien_q), .frc_q(frc_q)
);

// File: tb/gedge_port_bench.sv
module gedge_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pad_pu_en;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    gedge_port u_gedge_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu_en(pad_pu_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_pad(input logic [1:0] m, input logic [7:0] d);
        logic [7:0] oe, o;
        case (m)
            2'b01:   begin oe = 8'hFF; o = d;     end
            2'b10:   begin oe = ~d;    o = 8'h00; end
            2'b11:   begin oe = d;     o = 8'hFF; end
            default: begin oe = 8'h00; o = 8'h00; end
        endcase
        return {oe, o};
    endfunction

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [5:0] offs [6];
        offs = '{6'h08, 6'h0C, 6'h10, 6'h18, 6'h1C, 6'h20};

        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 64; a += 4) begin
            rd(6'(a), v);
            chk("R1 reg reset", v, 32'h0);
        end
        chk("R1 oe", {24'h0, pad_oe}, 32'h0);
        chk("R1 pullup", {24'h0, pad_pu_en}, 32'hFF);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 readback of writable registers (force and enable left cleared afterwards)
        for (int k = 0; k < 6; k++) begin
            wr(offs[k], 32'hDEAD_BEEF ^ (32'h1111_1111 * k));
            rd(offs[k], v);
            chk("R2 readback", v, (32'hDEAD_BEEF ^ (32'h1111_1111 * k)) &
                (offs[k] == 6'h0C ? 32'hFFFF : 32'hFF));
            wr(offs[k], 32'h0);
        end
        wr(6'h14, 32'hFF);
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h24, v);
        chk("R2 unmapped", v, 32'h0);

        // R5 pull-up active low
        for (int p = 0; p < 256; p += 37) begin
            wr(6'h10, 32'(p));
            idle(1);
            chk("R5 pullup", {24'h0, pad_pu_en}, {24'h0, ~8'(p)});
        end
        wr(6'h10, 32'h0);

        // R4 mode sweep, all pins same mode, several data patterns
        for (int m = 0; m < 4; m++) begin
            for (int dp = 0; dp < 256; dp += 51) begin
                wr(6'h08, 32'(dp));
                wr(6'h0C, {16'h0, {8{2'(m)}}});
                idle(1);
                chk("R4 pad", {16'h0, pad_oe, pad_out}, {16'h0, exp_pad(2'(m), 8'(dp))});
            end
        end

        // R6 data held in input mode
        wr(6'h0C, 32'h0);
        wr(6'h08, 32'h5A);
        idle(2);
        chk("R6 no drive in input", {24'h0, pad_oe}, 32'h0);
        rd(6'h08, v);
        chk("R6 data held", v, 32'h5A);
        wr(6'h0C, 32'h5555);
        idle(1);
        chk("R6 data driven", {24'h0, pad_out}, 32'h5A);

        // R3 input read in every mode; writes ignored
        for (int m = 0; m < 4; m++) begin
            wr(6'h0C, {16'h0, {8{2'(m)}}});
            @(negedge clk); pad_in = 8'h3C ^ 8'(m * 17);
            idle(3);
            rd(6'h04, v);
            chk("R3 input read", v, {24'h0, 8'h3C ^ 8'(m * 17)});
        end
        wr(6'h04, 32'hFF);
        rd(6'h04, v);
        chk("R3 write ignored", v, {24'h0, 8'h3C ^ 8'(3 * 17)});
        @(negedge clk); pad_in = 8'h00;
        wr(6'h0C, 32'h0);
        idle(4);
        wr(6'h14, 32'hFF);

        // R7 / R8 edge polarity sweep per pin
        for (int pin = 0; pin < 8; pin++) begin
            for (int pol = 0; pol < 2; pol++) begin
                wr(6'h20, pol ? (32'h1 << pin) : 32'h0);
                wr(6'h14, 32'hFF);
                @(negedge clk); pad_in[pin] = 1'b1;
                idle(4);
                rd(6'h14, v);
                chk("R7 rising", v, pol ? (32'h1 << pin) : 32'h0);
                wr(6'h14, 32'h0);
                rd(6'h14, v);
                chk("R8 write0 keeps", v, pol ? (32'h1 << pin) : 32'h0);
                wr(6'h14, 32'hFF);
                rd(6'h14, v);
                chk("R8 write1 clears", v, 32'h0);
                @(negedge clk); pad_in[pin] = 1'b0;
                idle(4);
                rd(6'h14, v);
                chk("R7 falling", v, pol ? 32'h0 : (32'h1 << pin));
                wr(6'h14, 32'hFF);
            end
        end

        // R11 interrupt combine
        wr(6'h1C, 32'h04);
        wr(6'h1C, 32'h00);
        idle(2);
        chk("R11 irq masked", {31'h0, irq}, 32'h0);
        wr(6'h18, 32'h04);
        idle(2);
        chk("R11 irq enabled", {31'h0, irq}, 32'h1);
        wr(6'h14, 32'h04);
        idle(2);
        chk("R11 irq cleared", {31'h0, irq}, 32'h0);
        wr(6'h18, 32'h0);

        // R9 set wins over clear; R10 force release
        wr(6'h1C, 32'h81);
        wr(6'h14, 32'h81);
        rd(6'h14, v);
        chk("R9 set over clear", v, 32'h81);
        wr(6'h1C, 32'h00);
        wr(6'h14, 32'hFF);
        idle(2);
        rd(6'h14, v);
        chk("R10 force released", v, 32'h0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule